// File: doc/BRIEF.md
# Dual-Domain Timer Register Bridge

This block is an 8-bit up-counter with two compare channels. The counter, the compare values and two control bytes are held in a timer clock domain. That domain is clocked either by the system clock or by a separate slow timer clock input, and a bit in the status byte picks which one. Software writes and reads every register through a simple port on the system clock.

When the slow clock is selected, each write first lands in a holding register. The value then crosses into the timer domain through a toggle handshake. Each register has its own busy flag, which hardware clears once the value has arrived. Software polls the status byte and waits for a busy bit to fall before it writes that register again.

Each compare match toggles an event line. That line is synchronized back to the system clock, where it becomes a one-cycle interrupt pulse. A match can also toggle that channel's waveform output.

Register map (3-bit address): 0 counter, 1 compare A, 2 compare B, 3 control A, 4 control B, 5 status.
- Control A: bit 0 lets a match on channel A toggle `wave_a`; bit 1 does the same for channel B and `wave_b`.
- Control B: bit 0 lets the counter run.

Top module: `tmr_async_bridge`

## Requirements
- R1: After reset, all six registers read 0, and `irq_a`, `irq_b`, `wave_a` and `wave_b` are low.
- R2: With status bit 5 at 0 (system clock mode), a write is visible on the read port in the cycle after the write edge, and status bits 4..0 stay 0.
- R3: With status bit 5 at 1, a write to a timer register sets its own busy bit in the status byte from the next cycle. The bits are: bit 4 counter, bit 3 compare A, bit 2 compare B, bit 1 control A, bit 0 control B.
- R4: A busy bit is cleared by hardware within 40 system cycles when the timer clock is 7 times slower than the system clock. The register then reads the written value.
- R5: A second write to a register whose busy bit is set replaces the held value. The register finally holds the later value.
- R6: Status bit 7 always reads 0. Bits 6 (external clock enable) and 5 (timer clock select) are read/write. Writes to bits 4..0 have no effect.
- R7: With control B bit 0 set, the counter rises by one per timer clock and wraps from 255 to 0. With the bit clear, it holds its value.
- R8: A timer clock on which the running counter equals a compare value gives exactly one single-cycle pulse on that channel's interrupt output. If the channel's enable bit in control A is set, it also toggles that channel's waveform output.
- R9: A write to the counter suppresses any compare match on the timer clock that follows the load.
- R10: Status bit 5 at 0 clocks the timer from the system clock; at 1 it clocks the timer from `tclk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tclk | input | 1 | Slow timer clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select for both writes and reads |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| irq_a | output | 1 | Compare A interrupt pulse |
| irq_b | output | 1 | Compare B interrupt pulse |
| wave_a | output | 1 | Channel A waveform output |
| wave_b | output | 1 | Channel B waveform output |

## Verification
The assertions check on every cycle that:
- a busy flag rises only after a write made in slow-clock mode;
- busy flags stay low in system-clock mode;
- a pending rewrite always has its busy flag set;
- a busy flag never drops while a rewrite is pending;
- the counter steps or holds exactly as control B says;
- a counter load blocks the next compare.

Only the bench scenarios can show the values that actually arrive after a crossing, the latest-value-wins result of a rewrite, the counter wrap, the interrupt pulse counts and waveform toggles, and the slower count rate once the slow clock is selected.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared constants for the timer register bridge.
// Assumes a 3-bit register address and five timer-domain registers.
package tmr_pkg;
    localparam int NREG     = 5;   // timer-domain registers crossing the bridge
    localparam int NCMP     = 2;   // compare channels
    localparam int ST_EXT   = 6;   // status: external clock enable
    localparam int ST_ASYNC = 5;   // status: timer clock select
    localparam int ST_BUSY  = 4;   // status: busy bit of register index 0

    typedef enum logic [2:0] {
        REG_CNT  = 3'd0,
        REG_CMPA = 3'd1,
        REG_CMPB = 3'd2,
        REG_CTLA = 3'd3,
        REG_CTLB = 3'd4,
        REG_STAT = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/tmr_xfer_chan.sv
`timescale 1ns/1ps
// One register crossing from the system domain into the timer domain.
// In slow-clock mode a write lands in a holding register and a toggle
// request is sent across. The timer side loads the value and returns the
// toggle as an acknowledge, and busy drops when that acknowledge is back.
// In system-clock mode the write data goes straight to the timer side.
// Assumes asel changes only while no transfer is in flight.
module tmr_xfer_chan #(
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tmr_clk,
    input  logic          t_rst_n,
    input  logic          asel,
    input  logic          wr_hit,
    input  logic [DW-1:0] wdata,
    output logic          busy_o,
    output logic          load_o,
    output logic [DW-1:0] val_o
);
    logic [DW-1:0]   hold;
    logic            req, pend, busy;
    logic [SYNC-1:0] ack_sy;
    logic [SYNC-1:0] req_sy;
    logic            tlast;
    logic            ack_back;

    assign ack_back = (ack_sy[SYNC-1] == req);

    // System side: capture the write, raise the request, retire on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold   <= '0;
            req    <= 1'b0;
            pend   <= 1'b0;
            busy   <= 1'b0;
            ack_sy <= '0;
        end else begin
            ack_sy <= {ack_sy[SYNC-2:0], tlast};
            if (wr_hit && asel) begin
                hold <= wdata;
                if (busy) begin
                    pend <= 1'b1;
                end else begin
                    req  <= ~req;
                    busy <= 1'b1;
                end
            end else if (busy && ack_back) begin
                if (pend) begin
                    req  <= ~req;
                    pend <= 1'b0;
                end else begin
                    busy <= 1'b0;
                end
            end
        end
    end

    // Timer side: synchronize the request toggle and keep its last value as the acknowledge.
    always_ff @(posedge tmr_clk) begin
        if (!t_rst_n) begin
            req_sy <= '0;
            tlast  <= 1'b0;
        end else begin
            req_sy <= {req_sy[SYNC-2:0], req};
            tlast  <= req_sy[SYNC-1];
        end
    end

    assign load_o = asel ? (req_sy[SYNC-1] ^ tlast) : wr_hit;
    assign val_o  = asel ? hold : wdata;
    assign busy_o = busy;

    assert_busy_from_async_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_hit && asel))
        else $error("busy rose without a slow-clock write");
    assert_sync_mode_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!asel && !busy) |=> !busy)
        else $error("busy set in system-clock mode");
    assert_pending_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> busy)
        else $error("pending rewrite without busy");
    assert_no_clear_while_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(pend))
        else $error("busy dropped with a rewrite pending");
endmodule

// File: rtl/tmr_evt_sync.sv
`timescale 1ns/1ps
// Turns a toggle from the timer domain into a one-cycle pulse on the
// system clock. Assumes the toggle changes at most once per few system cycles.
module tmr_evt_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_i,
    output logic pulse_o
);
    logic [SYNC-1:0] sy;
    logic            last;

    // Two-stage synchronizer plus a delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sy   <= '0;
            last <= 1'b0;
        end else begin
            sy   <= {sy[SYNC-2:0], tog_i};
            last <= sy[SYNC-1];
        end
    end

    assign pulse_o = sy[SYNC-1] ^ last;
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
// Timer-domain registers: counter, compare values, control bytes, and the
// compare logic that toggles the event lines and waveform outputs.
// Assumes the load strobes and values come from the bridge channels,
// in the register order of tmr_pkg.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                      tmr_clk,
    input  logic                      t_rst_n,
    input  logic [NREG-1:0]           ld,
    input  logic [NREG-1:0][DW-1:0]   val,
    output logic [DW-1:0]             cnt_o,
    output logic [NCMP-1:0][DW-1:0]   cmp_o,
    output logic [DW-1:0]             ctla_o,
    output logic [DW-1:0]             ctlb_o,
    output logic [NCMP-1:0]           wave_o,
    output logic [NCMP-1:0]           tog_o
);
    logic [DW-1:0]   cnt, ctla, ctlb;
    logic            blk;
    logic            run;
    logic [NCMP-1:0] match;

    assign run = ctlb[0];

    // Counter with load priority; a load also blocks the next compare.
    always_ff @(posedge tmr_clk) begin
        if (!t_rst_n) begin
            cnt  <= '0;
            blk  <= 1'b0;
            ctla <= '0;
            ctlb <= '0;
        end else begin
            if (ld[REG_CNT]) cnt <= val[REG_CNT];
            else if (run)    cnt <= cnt + 1'b1;
            blk <= ld[REG_CNT];
            if (ld[REG_CTLA]) ctla <= val[REG_CTLA];
            if (ld[REG_CTLB]) ctlb <= val[REG_CTLB];
        end
    end

    for (genvar ch = 0; ch < NCMP; ch++) begin : g_cmp
        logic [DW-1:0] cmp;
        logic          wave, tog;

        assign match[ch] = run && !blk && (cnt == cmp);

        // Compare register, event toggle and waveform for one channel.
        always_ff @(posedge tmr_clk) begin
            if (!t_rst_n) begin
                cmp  <= '0;
                wave <= 1'b0;
                tog  <= 1'b0;
            end else begin
                if (ld[REG_CMPA + ch]) cmp <= val[REG_CMPA + ch];
                if (match[ch]) begin
                    tog <= ~tog;
                    if (ctla[ch]) wave <= ~wave;
                end
            end
        end

        assign cmp_o[ch]  = cmp;
        assign wave_o[ch] = wave;
        assign tog_o[ch]  = tog;
    end

    assign cnt_o  = cnt;
    assign ctla_o = ctla;
    assign ctlb_o = ctlb;

    assert_load_blocks_match_R9: assert property (@(posedge tmr_clk) disable iff (!t_rst_n)
        ld[REG_CNT] |=> (match == '0))
        else $error("compare matched right after a counter load");
    assert_count_step_R7: assert property (@(posedge tmr_clk) disable iff (!t_rst_n)
        (run && !ld[REG_CNT]) |=> (cnt == DW'($past(cnt) + 1'b1)))
        else $error("counter did not step by one");
    assert_count_hold_R7: assert property (@(posedge tmr_clk) disable iff (!t_rst_n)
        (!run && !ld[REG_CNT]) |=> $stable(cnt))
        else $error("stopped counter moved");
endmodule

// File: rtl/tmr_async_bridge.sv
`timescale 1ns/1ps
// Top level: status byte, clock select, timer-domain reset synchronizer,
// one bridge channel per timer register, the timer core, and the
// interrupt synchronizers. Reads of timer registers are direct and
// intended for when the register is not busy and the counter is stopped.
module tmr_async_bridge
    import tmr_pkg::*;
#(
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tclk,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq_a,
    output logic          irq_b,
    output logic          wave_a,
    output logic          wave_b
);
    logic                    ext_en, asel;
    logic                    tmr_clk;
    logic [1:0]              t_rst_sy;
    logic                    t_rst_n;
    logic [NREG-1:0]         busy, ld;
    logic [NREG-1:0][DW-1:0] val;
    logic [DW-1:0]           cnt, ctla, ctlb;
    logic [NCMP-1:0][DW-1:0] cmp;
    logic [NCMP-1:0]         wave, tog, irq;
    logic [DW-1:0]           stat;

    // Status byte: only the two mode bits are writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_en <= 1'b0;
            asel   <= 1'b0;
        end else if (wr_en && addr == REG_STAT) begin
            ext_en <= wdata[ST_EXT];
            asel   <= wdata[ST_ASYNC];
        end
    end

    assign tmr_clk = asel ? tclk : clk;

    // Reset for the timer domain, released on the timer clock.
    always_ff @(posedge tmr_clk) begin
        t_rst_sy <= {t_rst_sy[0], rst_n};
    end
    assign t_rst_n = t_rst_sy[1];

    for (genvar i = 0; i < NREG; i++) begin : g_chan
        tmr_xfer_chan #(.DW(DW), .SYNC(SYNC)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tmr_clk (tmr_clk),
            .t_rst_n (t_rst_n),
            .asel    (asel),
            .wr_hit  (wr_en && (addr == 3'(i))),
            .wdata   (wdata),
            .busy_o  (busy[i]),
            .load_o  (ld[i]),
            .val_o   (val[i])
        );
    end

    tmr_core #(.DW(DW)) u_core (
        .tmr_clk (tmr_clk),
        .t_rst_n (t_rst_n),
        .ld      (ld),
        .val     (val),
        .cnt_o   (cnt),
        .cmp_o   (cmp),
        .ctla_o  (ctla),
        .ctlb_o  (ctlb),
        .wave_o  (wave),
        .tog_o   (tog)
    );

    for (genvar ch = 0; ch < NCMP; ch++) begin : g_irq
        tmr_evt_sync #(.SYNC(SYNC)) u_evt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tog_i   (tog[ch]),
            .pulse_o (irq[ch])
        );
    end

    // Assemble the status byte; busy of register i sits at bit ST_BUSY-i.
    always_comb begin
        stat           = '0;
        stat[ST_EXT]   = ext_en;
        stat[ST_ASYNC] = asel;
        for (int i = 0; i < NREG; i++) stat[ST_BUSY - i] = busy[i];
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            REG_CNT:  rdata = cnt;
            REG_CMPA: rdata = cmp[0];
            REG_CMPB: rdata = cmp[1];
            REG_CTLA: rdata = ctla;
            REG_CTLB: rdata = ctlb;
            REG_STAT: rdata = stat;
            default:  rdata = '0;
        endcase
    end

    assign irq_a  = irq[0];
    assign irq_b  = irq[1];
    assign wave_a = wave[0];
    assign wave_b = wave[1];
endmodule

// File: tb/tmr_async_bridge_bench.sv
`timescale 1ns/1ps
module tmr_async_bridge_bench;
    logic       clk = 1'b0, tclk = 1'b0, rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq_a, irq_b, wave_a, wave_b;

    int total = 0, bad = 0;
    int na = 0, nb = 0, wide = 0;
    logic prev_a = 1'b0, prev_b = 1'b0;
    bit done = 0;

    typedef struct {
        logic [2:0] a;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t q[$];

    always #5  clk  = ~clk;
    always #35 tclk = ~tclk;

    tmr_async_bridge u_tmr_async_bridge (
        .clk(clk), .rst_n(rst_n), .tclk(tclk), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b),
        .wave_a(wave_a), .wave_b(wave_b)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected read per cycle and compares it.
    always @(posedge clk) begin
        item_t it;
        #2;
        if (q.size() > 0) begin
            it = q.pop_front();
            chk(rdata == it.exp, it.tag, rdata, it.exp);
        end
    end

    // Interrupt pulse counters and width tracking.
    always @(negedge clk) begin
        if (irq_a) begin na++; if (prev_a) wide++; end
        if (irq_b) begin nb++; if (prev_b) wide++; end
        prev_a = irq_a;
        prev_b = irq_b;
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_exp(input logic [2:0] a, input logic [7:0] e, input string tag);
        item_t it;
        addr = a;
        it.a = a; it.exp = e; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        addr = 3'd5;
        #1;
        while (rdata[4:0] != 5'd0 && n < 500) begin
            @(negedge clk);
            #1;
            n++;
        end
    endtask

    task automatic clr_irq();
        na = 0; nb = 0; wide = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        idle(4);

        // R1 reset state
        for (int i = 0; i < 6; i++) rd_exp(3'(i), 8'h00, "R1 reset register");
        chk(!irq_a && !irq_b && !wave_a && !wave_b, "R1 outputs low", {irq_a, irq_b, wave_a, wave_b}, 0);

        // R2 system-clock mode writes
        wr(3'd1, 8'd2);
        rd_exp(3'd5, 8'h00, "R2 no busy in sync mode");
        rd_exp(3'd1, 8'd2, "R2 compare A readback");
        wr(3'd2, 8'd200);
        // R6 status write mask
        wr(3'd5, 8'h9F);
        rd_exp(3'd5, 8'h00, "R6 read-only and reserved bits ignore writes");
        wr(3'd0, 8'd250);
        rd_exp(3'd0, 8'd250, "R2 counter readback");

        // R7 count and wrap, R8 match on A
        wr(3'd3, 8'h03);
        clr_irq();
        wr(3'd4, 8'h01);
        idle(9);
        wr(3'd4, 8'h00);
        rd_exp(3'd0, 8'd4, "R7 counter wrapped 250+10");
        idle(6);
        chk(na == 1, "R8 one irq_a pulse", na, 1);
        chk(nb == 0, "R8 no irq_b pulse", nb, 0);
        chk(wave_a == 1'b1 && wave_b == 1'b0, "R8 wave A toggled only", {wave_a, wave_b}, 2);
        chk(wide == 0, "R8 single-cycle pulse", wide, 0);
        idle(5);
        rd_exp(3'd0, 8'd4, "R7 counter holds when stopped");

        // R9 load suppresses next match
        clr_irq();
        wr(3'd4, 8'h01);
        wr(3'd0, 8'd2);
        wr(3'd4, 8'h00);
        rd_exp(3'd0, 8'd3, "R9 counter after load");
        idle(6);
        chk(na == 0, "R9 match suppressed after load", na, 0);

        // R9 contrast: match one clock later still fires
        clr_irq();
        wr(3'd0, 8'd1);
        wr(3'd4, 8'h01);
        idle(2);
        wr(3'd4, 8'h00);
        rd_exp(3'd0, 8'd4, "R9 contrast counter");
        idle(6);
        chk(na == 1, "R9 contrast match fires", na, 1);
        chk(wave_a == 1'b0, "R8 wave A toggled back", wave_a, 0);

        // R6 / R10 enter slow-clock mode
        wr(3'd5, 8'h40);
        wr(3'd5, 8'h60);
        rd_exp(3'd5, 8'h60, "R6 mode bits readback");

        // R3 / R4 single transfer
        wr(3'd2, 8'h33);
        rd_exp(3'd5, 8'h64, "R3 compare B busy");
        wait_idle(n);
        chk(n <= 40, "R4 busy cleared in time", n, 40);
        idle(1);
        rd_exp(3'd2, 8'h33, "R4 compare B arrived");

        // R5 overwrite while busy
        wr(3'd1, 8'h10);
        wr(3'd1, 8'h20);
        rd_exp(3'd5, 8'h68, "R3 compare A busy");
        wait_idle(n);
        idle(1);
        rd_exp(3'd1, 8'h20, "R5 latest value wins");

        // R3 two busy flags at once
        wr(3'd0, 8'd0);
        wr(3'd3, 8'h03);
        rd_exp(3'd5, 8'h72, "R3 counter and control A busy");
        wait_idle(n);
        idle(1);
        rd_exp(3'd0, 8'd0, "R4 counter arrived");
        rd_exp(3'd3, 8'h03, "R4 control A arrived");
        wr(3'd1, 8'd5);
        wait_idle(n);
        idle(1);

        // R10 slow clock drives counting
        clr_irq();
        wr(3'd4, 8'h01);
        rd_exp(3'd5, 8'h61, "R3 control B busy");
        wait_idle(n);
        idle(200);
        wr(3'd4, 8'h00);
        wait_idle(n);
        idle(2);
        addr = 3'd0;
        #1;
        chk(rdata >= 8'd20 && rdata <= 8'd45, "R10 count follows slow clock", rdata, 32);
        idle(6);
        chk(na == 1, "R8 async irq_a pulse", na, 1);
        chk(nb == 0, "R8 async no irq_b", nb, 0);
        chk(wave_a == 1'b1, "R8 async wave A toggled", wave_a, 1);

        idle(3);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule